// File: doc/BRIEF.md
# Double-Buffered Period/Duty PWM Generator

This block drives one pulse-width-modulated output from an up-counting time base. A period register sets how many counter steps make one period. A duty value, one fractional counter width wider, sets how long the output stays high at the start of each period. The two extra duty bits are compared against a two-bit sub-step count that sits below the main counter, so each counter step is split into four sub-steps. A prescaler sets how many clocks one sub-step takes: 1, 4 or 16.

Software writes the period, the upper duty bits, the lower duty bits and a mode word through single-cycle write strobes that share one data bus. The duty value is held in a staging buffer and is copied into the active duty latch only when a period ends, or when the block is enabled. The active latch can be read at any time. An active duty of zero keeps the output low. A duty longer than the period keeps the output high.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset the output is low, the active duty reads zero and the block is disabled.
- R2: While enabled with period value P and prescale divide N, one period lasts (P+1)·4·N clocks and then repeats, with no gap between periods.
- R3: The mode word uses wrData[2] as enable and wrData[1:0] as prescale select: 00 divides by 1, 01 by 4, 10 and 11 by 16.
- R4: With active duty D, where 0 < D < (P+1)·4, the output is high for exactly D·N clocks from the start of every period and then low for the rest of the period.
- R5: A duty write loads only the staging buffer. wrDutyHi writes wrData into duty bits [W+1:2] and wrDutyLo writes wrData[1:0] into duty bits [1:0]. The active duty and the output do not change until the next period boundary, and the staged value is used from that boundary onward.
- R6: When the duty value that starts a period is zero, the output stays low for the whole period.
- R7: When the duty value is equal to or greater than (P+1)·4, the output stays high for the whole period.
- R8: A mode write with enable clear forces the output low on the next clock and freezes the time base. The active duty keeps its value.
- R9: A mode write with enable set restarts the time base at zero and copies the staging buffer into the active duty. The output goes high at once if that value is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrPeriod | input | 1 | Write strobe for the period register |
| wrDutyHi | input | 1 | Write strobe for the upper duty bits in the staging buffer |
| wrDutyLo | input | 1 | Write strobe for the two lower duty bits in the staging buffer |
| wrMode | input | 1 | Write strobe for the mode word (enable and prescale select) |
| wrData | input | CNT_W | Shared write data |
| activeDuty | output | CNT_W+2 | Read port of the active duty latch |
| pwmOut | output | 1 | PWM output |

## Verification
The bench builds the block with CNT_W set to 4. This gives a 6-bit duty and periods of at most 64 sub-steps. With this size, every duty value from 0 to 63 can be swept against several period values, so the cases of zero duty, duty equal to the period and duty beyond the period all occur. At divide by 1, each configuration is compared clock by clock over two full periods against an arithmetic model of the waveform. Shorter sweeps at divide by 4 and by 16, using both codes that select 16, cover the prescaler. Separate runs cover a duty change in mid-period, a disable while the output is high, and duty writes made while the block is idle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Width of the sub-step count that extends the counter.
  localparam int SUB_W = 2;

  // Bit positions inside the mode word.
  localparam int MODE_EN_BIT = 2;

  // Prescale select codes.
  typedef enum logic [1:0] {
    PRE_DIV1  = 2'd0,
    PRE_DIV4  = 2'd1,
    PRE_DIV16 = 2'd2,
    PRE_ALT16 = 2'd3
  } preSel_t;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic start;   // enable write: restart and load the active duty
    logic stop;    // disable write: force the output low
    logic tick;    // the sub-step position advances at this edge
    logic wrap;    // the period ends at this edge
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int POS_W = CNT_W + SUB_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrPeriod,
  input  logic             wrMode,
  input  logic [CNT_W-1:0] wrData,
  output pwmStrobe_t       strobe,
  output logic [POS_W-1:0] pos
);

  localparam int PRE_W = 4;
  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  logic             runEn;
  preSel_t          preSel;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic [SUB_W-1:0] subCnt;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] periodReg;
  logic             tick;
  logic             wrapHit;

  // Terminal count of the prescaler for each select code.
  always_comb begin
    unique case (preSel)
      PRE_DIV1:  preLimit = 4'd0;
      PRE_DIV4:  preLimit = 4'd3;
      default:   preLimit = 4'd15;
    endcase
  end

  assign tick    = runEn && (preCnt == preLimit);
  assign wrapHit = tick && (subCnt == SUB_LAST) && (baseCnt == periodReg);

  always_comb begin
    strobe.start = wrMode && wrData[MODE_EN_BIT];
    strobe.stop  = wrMode && !wrData[MODE_EN_BIT];
    strobe.tick  = tick && !wrMode;
    strobe.wrap  = wrapHit && !wrMode;
  end

  assign pos = {baseCnt, subCnt};

  // Period register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
    end else if (wrPeriod) begin
      periodReg <= wrData;
    end
  end

  // Mode register and time base.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      preSel  <= PRE_DIV1;
      preCnt  <= '0;
      subCnt  <= '0;
      baseCnt <= '0;
    end else if (wrMode) begin
      runEn   <= wrData[MODE_EN_BIT];
      preSel  <= preSel_t'(wrData[1:0]);
      preCnt  <= '0;
      subCnt  <= '0;
      baseCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      subCnt <= subCnt + 1'b1;
      if (subCnt == SUB_LAST) begin
        baseCnt <= wrapHit ? '0 : baseCnt + 1'b1;
      end
    end else if (runEn) begin
      preCnt <= preCnt + 1'b1;
    end
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLimit);  // R3

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !tick && !wrMode) |=> $stable(pos));  // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> (pos == '0));  // R2

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !wrMode) |=> ($stable(pos) && $stable(preCnt)));  // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.start, strobe.stop, strobe.wrap}));  // R9

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int POS_W  = CNT_W + SUB_W,
  localparam int DUTY_W = CNT_W + SUB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic [POS_W-1:0]  pos,
  input  logic              wrDutyHi,
  input  logic              wrDutyLo,
  input  logic [CNT_W-1:0]  wrData,
  output logic [DUTY_W-1:0] activeDuty,
  output logic              pwmOut
);

  logic [CNT_W-1:0] stageHi;
  logic [SUB_W-1:0] stageLo;
  logic [CNT_W-1:0] liveHi;
  logic [SUB_W-1:0] liveLo;   // separate latch for the two low bits
  logic [DUTY_W-1:0] stageDuty;
  logic [POS_W:0]    nextPos;
  logic              clearHit;
  logic              loadLive;
  logic              outReg;

  assign stageDuty  = {stageHi, stageLo};
  assign activeDuty = {liveHi, liveLo};
  assign loadLive   = strobe.start || strobe.wrap;

  // Position after this tick, one bit wider so that it cannot wrap.
  assign nextPos  = {1'b0, pos} + {{POS_W{1'b0}}, 1'b1};
  assign clearHit = strobe.tick && (nextPos == {1'b0, activeDuty});

  // Staging buffer, written at any time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageHi <= '0;
      stageLo <= '0;
    end else begin
      if (wrDutyHi) stageHi <= wrData;
      if (wrDutyLo) stageLo <= wrData[SUB_W-1:0];
    end
  end

  // Active duty latch, loaded only on a restart or a period boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveHi <= '0;
      liveLo <= '0;
    end else if (loadLive) begin
      liveHi <= stageHi;
      liveLo <= stageLo;
    end
  end

  // Set/reset output stage. A boundary takes priority over a compare clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= 1'b0;
    end else if (strobe.stop) begin
      outReg <= 1'b0;
    end else if (loadLive) begin
      outReg <= (stageDuty != '0);
    end else if (clearHit) begin
      outReg <= 1'b0;
    end
  end

  assign pwmOut = outReg;

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !loadLive |=> $stable(activeDuty));  // R5

  AST_DUTY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadLive |=> (activeDuty == $past(stageDuty)));  // R5

  AST_ZERO_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (activeDuty == '0) |-> !pwmOut);  // R6

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stop |=> !pwmOut);  // R8

  AST_START_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.start && (stageDuty != '0)) |=> pwmOut);  // R9

endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int POS_W  = CNT_W + SUB_W,
  localparam int DUTY_W = CNT_W + SUB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrPeriod,
  input  logic              wrDutyHi,
  input  logic              wrDutyLo,
  input  logic              wrMode,
  input  logic [CNT_W-1:0]  wrData,
  output logic [DUTY_W-1:0] activeDuty,
  output logic              pwmOut
);

  pwmStrobe_t       strobe;
  logic [POS_W-1:0] pos;

  pwm_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrPeriod (wrPeriod),
    .wrMode   (wrMode),
    .wrData   (wrData),
    .strobe   (strobe),
    .pos      (pos)
  );

  pwm_datapath #(.CNT_W(CNT_W)) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pos        (pos),
    .wrDutyHi   (wrDutyHi),
    .wrDutyLo   (wrDutyLo),
    .wrData     (wrData),
    .activeDuty (activeDuty),
    .pwmOut     (pwmOut)
  );

endmodule

// File: tb/pwm_dbuf_tb_top.sv
`timescale 1ns/1ps
module pwm_dbuf_tb_top;

  localparam int CNT_W  = 4;
  localparam int DUTY_W = CNT_W + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrPeriod = 1'b0;
  logic              wrDutyHi = 1'b0;
  logic              wrDutyLo = 1'b0;
  logic              wrMode = 1'b0;
  logic [CNT_W-1:0]  wrData = '0;
  logic [DUTY_W-1:0] activeDuty;
  logic              pwmOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dbuf #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrPeriod(wrPeriod), .wrDutyHi(wrDutyHi),
    .wrDutyLo(wrDutyLo), .wrMode(wrMode), .wrData(wrData),
    .activeDuty(activeDuty), .pwmOut(pwmOut)
  );

  function automatic int divOf(input int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    return 16;
  endfunction

  // Expected output in state k after a restart: high while the sub-step index is below the duty.
  function automatic bit expOut(input int k, input int per, input int sel, input int duty);
    int span = (per + 1) * 4;
    int p = (k / divOf(sel)) % span;
    return (duty != 0) && (p < duty);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 period, 1 duty high bits, 2 duty low bits, 3 mode
  task automatic writeReg(input int kind, input int val);
    @(negedge clk);
    wrData   = CNT_W'(val);
    wrPeriod = (kind == 0);
    wrDutyHi = (kind == 1);
    wrDutyLo = (kind == 2);
    wrMode   = (kind == 3);
    @(posedge clk);
    #1;
    wrPeriod = 1'b0; wrDutyHi = 1'b0; wrDutyLo = 1'b0; wrMode = 1'b0;
  endtask

  task automatic setup(input int per, input int sel, input int duty);
    writeReg(3, 0);
    writeReg(0, per);
    writeReg(1, duty >> 2);
    writeReg(2, duty & 3);
    writeReg(3, 4 | sel);
  endtask

  // One configuration, compared clock by clock over two periods.
  task automatic runCfg(input int per, input int sel, input int duty);
    int span = (per + 1) * 4;
    int n = 2 * span * divOf(sel);
    int errK = -1;
    int errAct = 0;
    int errExp = 0;
    string tag;
    setup(per, sel, duty);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) check(activeDuty == DUTY_W'(duty), "R9 load on enable", activeDuty, duty);
      if (errK < 0 && pwmOut != expOut(k, per, sel, duty)) begin
        errK = k; errAct = pwmOut; errExp = expOut(k, per, sel, duty);
      end
    end
    if (duty == 0) tag = "R6 zero duty";
    else if (duty >= span) tag = "R7 full duty";
    else if (sel == 0) tag = "R4 R2 duty window";
    else tag = "R3 R2 prescaled window";
    if (errK >= 0) $display("  mismatch per=%0d sel=%0d duty=%0d at k=%0d", per, sel, duty, errK);
    check(errK < 0, tag, errAct, errExp);
  endtask

  initial begin
    int perList[5] = '{0, 1, 2, 5, 15};
    int slowDuty[8] = '{0, 1, 2, 3, 5, 8, 16, 17};

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(pwmOut == 1'b0, "R1 output after reset", pwmOut, 0);
    check(activeDuty == '0, "R1 active duty after reset", activeDuty, 0);

    // R5: duty writes while idle reach only the staging buffer
    writeReg(0, 3);
    writeReg(1, 2);
    writeReg(2, 3);
    repeat (5) @(negedge clk);
    check(activeDuty == '0, "R5 idle duty write held in buffer", activeDuty, 0);
    check(pwmOut == 1'b0, "R5 R1 output stays low while idle", pwmOut, 0);
    writeReg(3, 4);
    @(negedge clk);
    check(activeDuty == DUTY_W'(11), "R9 enable loads staged duty", activeDuty, 11);
    check(pwmOut == 1'b1, "R9 output set on enable", pwmOut, 1);

    // Full duty sweep at divide by 1
    foreach (perList[i]) begin
      for (int d = 0; d < 64; d++) runCfg(perList[i], 0, d);
    end

    // Prescaled sweeps, including the alternate divide-by-16 code
    foreach (slowDuty[j]) begin
      runCfg(0, 1, slowDuty[j]);
      runCfg(3, 1, slowDuty[j]);
      runCfg(3, 2, slowDuty[j]);
    end
    runCfg(1, 3, 5);
    runCfg(2, 3, 13);

    // R5: duty change mid-period takes effect at the boundary only
    begin
      int span = 16;
      int errK = -1;
      int errAct = 0;
      int errExp = 0;
      setup(3, 0, 5);
      for (int k = 0; k < 3 * span; k++) begin
        int dExp;
        @(negedge clk);
        wrDutyHi = 1'b0; wrDutyLo = 1'b0;
        dExp = (k >= span) ? 12 : 5;
        if (errK < 0 && (activeDuty != DUTY_W'(dExp) || pwmOut != expOut(k, 3, 0, dExp))) begin
          errK = k; errAct = activeDuty; errExp = dExp;
        end
        if (k == 6) begin wrData = 4'd3; wrDutyHi = 1'b1; end
        if (k == 7) begin wrData = 4'd0; wrDutyLo = 1'b1; end
      end
      if (errK >= 0) $display("  mismatch mid-period update at k=%0d", errK);
      check(errK < 0, "R5 buffered duty update", errAct, errExp);
    end

    // R8: disable forces low and keeps the active duty
    begin
      int highs = 0;
      setup(3, 0, 9);
      repeat (4) @(negedge clk);
      check(pwmOut == 1'b1, "R4 output high before disable", pwmOut, 1);
      writeReg(3, 0);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (pwmOut) highs++;
      end
      check(highs == 0, "R8 output low after disable", highs, 0);
      check(activeDuty == DUTY_W'(9), "R8 active duty kept", activeDuty, 9);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule